// File: doc/BRIEF.md
# Five-Port Serial Joypad Multiplexer

This block is the logic that sits in a controller port between a host and up to five two-button pads. The host drives two level lines: a group select (`sel_i`) and a clear/strobe line (`clr_i`). It reads back a single 4-bit nibble. Each pad has eight switches, split into a direction group and a button group. `sel_i` chooses which group appears on the nibble. Switch states reach the nibble inverted, so a pressed switch reads 0.

An internal port counter decides which pad is on the nibble. The host starts a scan by raising `clr_i` while `sel_i` is high, which points the counter at the first pad. Each later rising edge of `sel_i` taken while `clr_i` is low moves the counter to the next pad. After the fifth pad has been stepped past, the nibble reads all zeros until the next scan start. An empty pad slot reads all ones.

Both lines are sampled into the block's clock domain, and edges are found by comparing each line with its registered copy. The counter powers up exhausted, so no pad data appears until the host performs a scan start. Right after a scan start, and for as long as `clr_i` stays high, the first pad's data is shown even though `clr_i` is high. At all other times a high `clr_i` forces the nibble to zero.

Top module: `joy_tap_mux`

## Requirements
- R1: With `sel_i` high, the nibble shows the selected pad's direction group: bit 3 is not-Left, bit 2 is not-Right, bit 1 is not-Down and bit 0 is not-Up. The switch bits within a pad's byte of `pad_sw_i` are 0 Up, 1 Down, 2 Right, 3 Left, 4 I, 5 II, 6 Select and 7 Run.
- R2: With `sel_i` low, the nibble shows the button group: bit 3 is not-Run, bit 2 is not-Select, bit 1 is not-II and bit 0 is not-I.
- R3: A rising edge of `sel_i` while `clr_i` is low moves the selection to the next pad. A rising edge of `sel_i` while `clr_i` is high leaves the selection unchanged.
- R4: A rising edge of `clr_i` while `sel_i` is high selects pad 1 (byte 0 of `pad_sw_i`). A rising edge of `clr_i` while `sel_i` is low does not change the selection.
- R5: Once the fifth pad has been stepped past, the nibble reads 0000 under any line levels until the next scan start. Further `sel_i` edges do not move the selection.
- R6: A selected pad whose bit in `pad_present_i` is 0 reads 1111, whatever its switch inputs.
- R7: Outside the post-start window, a high `clr_i` forces the nibble to 0000.
- R8: From a scan start until `clr_i` next goes low, the selected pad's data is shown despite `clr_i` being high. This is pad 1's direction group with `sel_i` high, and its button group with `sel_i` low.
- R9: After reset the selection is exhausted, so the nibble reads 0000 until the first scan start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | Group select / advance line from the host |
| clr_i | input | 1 | Clear / scan-start line from the host |
| pad_sw_i | input | 40 | Active-high switch states, 8 per pad, pad 1 in bits 7..0 |
| pad_present_i | input | 5 | One bit per pad slot, 1 when a pad is connected |
| nib_o | output | 4 | Active-low data nibble returned to the host |

## Verification
The hidden state is small: a saturating pad index and a one-bit post-start window. Any fault in that state shows at the port within one clock after the line change that should have moved it. A counter that advances on the wrong edge or at the wrong level puts the next pad's pattern on the nibble one step early or late. A missed saturation brings pad data back where zeros are due. A window flag that stays set too long turns an expected 0000 under a high `clr_i` into live pad data. Giving every pad a distinct switch pattern, and leaving one slot empty, makes each selection visibly different at the nibble.

// File: rtl/joy_tap_pkg.sv
package joy_tap_pkg;

  localparam int SW_W  = 8;
  localparam int NIB_W = 4;

  typedef enum logic [1:0] {
    SRC_ZERO = 2'd0,
    SRC_ONES = 2'd1,
    SRC_PAD  = 2'd2
  } nib_src_e;

  // Per-pad switch byte: [3:0] direction group, [7:4] button group.
  // Output is active low.
  function automatic logic [NIB_W-1:0] pad_nibble(input logic [SW_W-1:0] sw,
                                                  input logic            dir_grp);
    logic [NIB_W-1:0] grp;
    grp = dir_grp ? sw[NIB_W-1:0] : sw[SW_W-1:NIB_W];
    return ~grp;
  endfunction

  // Saturating step of the port index.
  function automatic int unsigned index_step(input int unsigned cur,
                                             input int unsigned last);
    return (cur >= last) ? last : cur + 1;
  endfunction

endpackage

// File: rtl/joy_edge_det.sv
module joy_edge_det #(
  parameter int          W       = 2,
  parameter logic [W-1:0] RST_LVL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] lvl_q_o,
  output logic [W-1:0] rise_o
);

  logic [W-1:0] lvl_q;

  // Reset level is high so lines already high out of reset give no edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= RST_LVL;
    else        lvl_q <= lvl_i;
  end

  for (genvar g = 0; g < W; g++) begin : g_rise
    assign rise_o[g] = lvl_i[g] & ~lvl_q[g];
  end

  assign lvl_q_o = lvl_q;

endmodule

// File: rtl/joy_port_ctr.sv
module joy_port_ctr #(
  parameter int NUM_PADS = 5,
  parameter int CNT_W    = $clog2(NUM_PADS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_i,
  input  logic             clr_i,
  input  logic             sel_rise_i,
  input  logic             clr_rise_i,
  output logic [CNT_W-1:0] idx_o,
  output logic             exhausted_o,
  output logic             window_o,
  output logic             start_evt_o,
  output logic             adv_evt_o
);

  localparam logic [CNT_W-1:0] IDX_EXH = CNT_W'(NUM_PADS);

  logic [CNT_W-1:0] idx_q, idx_d;
  logic             win_q, win_d;
  logic             start_evt, adv_evt;

  assign start_evt = clr_rise_i & sel_i;
  assign adv_evt   = sel_rise_i & ~clr_i;

  always_comb begin
    idx_d = idx_q;
    if (start_evt)    idx_d = '0;
    else if (adv_evt) idx_d = CNT_W'(joy_tap_pkg::index_step(int'(idx_q), NUM_PADS));
  end

  always_comb begin
    win_d = win_q;
    if (start_evt)   win_d = 1'b1;
    else if (!clr_i) win_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= IDX_EXH;
      win_q <= 1'b0;
    end else begin
      idx_q <= idx_d;
      win_q <= win_d;
    end
  end

  assign idx_o       = idx_q;
  assign exhausted_o = (idx_q == IDX_EXH);
  assign window_o    = win_q;
  assign start_evt_o = start_evt;
  assign adv_evt_o   = adv_evt;

  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= IDX_EXH); // R5
  AST_START_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> idx_q == '0); // R4
  AST_ADV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_evt && !start_evt && idx_q != IDX_EXH) |=> idx_q == $past(idx_q) + 1'b1); // R3
  AST_EXH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_q == IDX_EXH && !start_evt) |=> idx_q == IDX_EXH); // R5
  AST_CLR_NO_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !start_evt) |=> $stable(idx_q)); // R3
  AST_WIN_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> !win_q); // R8

endmodule

// File: rtl/joy_nib_sel.sv
module joy_nib_sel #(
  parameter int NUM_PADS = 5,
  parameter int CNT_W    = $clog2(NUM_PADS + 1),
  parameter int SW_W     = joy_tap_pkg::SW_W,
  parameter int NIB_W    = joy_tap_pkg::NIB_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_PADS*SW_W-1:0] pad_sw_i,
  input  logic [NUM_PADS-1:0]      pad_present_i,
  input  logic [CNT_W-1:0]         idx_i,
  input  logic                     exhausted_i,
  input  logic                     window_i,
  input  logic                     sel_i,
  input  logic                     clr_i,
  output logic [NIB_W-1:0]         nib_o,
  output joy_tap_pkg::nib_src_e    src_o
);
  import joy_tap_pkg::*;

  logic [NIB_W-1:0] pad_nib [NUM_PADS];
  logic [NIB_W-1:0] sel_nib;
  logic             sel_present;
  logic             clr_block;

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    assign pad_nib[p] = pad_nibble(pad_sw_i[p*SW_W +: SW_W], sel_i);
  end

  always_comb begin
    sel_nib     = '0;
    sel_present = 1'b0;
    for (int p = 0; p < NUM_PADS; p++) begin
      if (idx_i == CNT_W'(p)) begin
        sel_nib     = pad_nib[p];
        sel_present = pad_present_i[p];
      end
    end
  end

  assign clr_block = clr_i & ~window_i;

  always_comb begin
    if (clr_block || exhausted_i) src_o = SRC_ZERO;
    else if (!sel_present)        src_o = SRC_ONES;
    else                          src_o = SRC_PAD;
  end

  always_comb begin
    case (src_o)
      SRC_ONES: nib_o = '1;
      SRC_PAD:  nib_o = sel_nib;
      default:  nib_o = '0;
    endcase
  end

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !window_i) |-> nib_o == '0); // R7
  AST_EXH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    exhausted_i |-> nib_o == '0); // R5
  AST_EMPTY_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (!exhausted_i && !clr_i && !pad_present_i[0] && idx_i == '0) |-> nib_o == '1); // R6

endmodule

// File: rtl/joy_tap_mux.sv
module joy_tap_mux #(
  parameter int NUM_PADS = 5,
  parameter int SW_W     = joy_tap_pkg::SW_W,
  parameter int NIB_W    = joy_tap_pkg::NIB_W,
  parameter int CNT_W    = $clog2(NUM_PADS + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sel_i,
  input  logic                     clr_i,
  input  logic [NUM_PADS*SW_W-1:0] pad_sw_i,
  input  logic [NUM_PADS-1:0]      pad_present_i,
  output logic [NIB_W-1:0]         nib_o
);

  logic [1:0]            line_q, line_rise;
  logic                  sel_rise, clr_rise;
  logic [CNT_W-1:0]      idx;
  logic                  exhausted, window, start_evt, adv_evt;
  joy_tap_pkg::nib_src_e nib_src;

  joy_edge_det #(.W(2), .RST_LVL(2'b11)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  ({clr_i, sel_i}),
    .lvl_q_o(line_q),
    .rise_o (line_rise)
  );

  assign sel_rise = line_rise[0];
  assign clr_rise = line_rise[1];

  joy_port_ctr #(.NUM_PADS(NUM_PADS), .CNT_W(CNT_W)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_i      (sel_i),
    .clr_i      (clr_i),
    .sel_rise_i (sel_rise),
    .clr_rise_i (clr_rise),
    .idx_o      (idx),
    .exhausted_o(exhausted),
    .window_o   (window),
    .start_evt_o(start_evt),
    .adv_evt_o  (adv_evt)
  );

  joy_nib_sel #(.NUM_PADS(NUM_PADS), .CNT_W(CNT_W), .SW_W(SW_W), .NIB_W(NIB_W)) u_nib (
    .clk          (clk),
    .rst_n        (rst_n),
    .pad_sw_i     (pad_sw_i),
    .pad_present_i(pad_present_i),
    .idx_i        (idx),
    .exhausted_i  (exhausted),
    .window_i     (window),
    .sel_i        (sel_i),
    .clr_i        (clr_i),
    .nib_o        (nib_o),
    .src_o        (nib_src)
  );

  AST_START_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |-> (sel_i && clr_i && !line_q[1])); // R4
  AST_ADV_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_evt && adv_evt)); // R3
  AST_WIN_SHOWS_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    (window && clr_i && !exhausted && pad_present_i[0] && idx == '0)
      |-> nib_src == joy_tap_pkg::SRC_PAD); // R8

endmodule

// File: tb/sim_joy_tap_mux.sv
module sim_joy_tap_mux;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sel = 1'b0;
  logic          clr = 1'b0;
  logic [7:0]    pad [NP];
  logic [NP-1:0] present;
  logic [NP*8-1:0] sw_flat;
  logic [3:0]    nib;
  int            n_chk = 0;
  int            n_bad = 0;
  bit            done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int i = 0; i < NP; i++) sw_flat[i*8 +: 8] = pad[i];
  end

  joy_tap_mux u0 (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .clr_i(clr),
    .pad_sw_i(sw_flat), .pad_present_i(present), .nib_o(nib)
  );

  // Expected values from the named switch positions.
  function automatic logic [3:0] exp_dir(input int p);
    logic up, dn, rt, lf;
    up = pad[p][0]; dn = pad[p][1]; rt = pad[p][2]; lf = pad[p][3];
    if (!present[p]) return 4'b1111;
    return {!lf, !rt, !dn, !up};
  endfunction

  function automatic logic [3:0] exp_btn(input int p);
    logic b1, b2, sl, rn;
    b1 = pad[p][4]; b2 = pad[p][5]; sl = pad[p][6]; rn = pad[p][7];
    if (!present[p]) return 4'b1111;
    return {!rn, !sl, !b2, !b1};
  endfunction

  task automatic lines(input logic s, input logic c);
    @(negedge clk);
    sel = s;
    clr = c;
    @(negedge clk);
  endtask

  task automatic check(input logic [3:0] exp, input string req);
    n_chk++;
    if (nib !== exp) begin
      n_bad++;
      $display("FAIL %s: nibble actual %b expected %b", req, nib, exp);
    end
  endtask

  task automatic t_powerup;
    check(4'b0000, "R9 after reset");
    lines(0, 0); check(4'b0000, "R9 lines low");
    lines(1, 0); check(4'b0000, "R9 sel edge before start");
    lines(0, 0); check(4'b0000, "R9 sel low before start");
  endtask

  task automatic t_clr_sel_low_no_start;
    lines(0, 1); check(4'b0000, "R7 clr high no window");
    lines(0, 0); check(4'b0000, "R4 clr edge with sel low is no start");
  endtask

  task automatic t_full_scan(input string tag);
    lines(1, 0); check(4'b0000, "R5 sel high before start");
    lines(1, 1); check(exp_dir(0), "R8 pad1 dir with clr high");
    lines(1, 0); check(exp_dir(0), "R1 pad1 dir");
    lines(0, 0); check(exp_btn(0), "R2 pad1 btn");
    for (int p = 1; p < NP; p++) begin
      lines(1, 0);
      check(exp_dir(p), p == 3 ? "R6 empty slot dir" : "R3 next pad dir");
      lines(0, 0);
      check(exp_btn(p), p == 3 ? "R6 empty slot btn" : "R2 btn");
    end
    lines(1, 0); check(4'b0000, "R5 exhausted sel high");
    lines(0, 0); check(4'b0000, "R5 exhausted sel low");
    lines(1, 0); check(4'b0000, "R5 saturated");
    $display("scan %s done", tag);
  endtask

  task automatic t_clr_blocks;
    lines(1, 1); check(exp_dir(0), "R4 restart to pad1");
    lines(0, 1); check(exp_btn(0), "R8 window holds btn");
    lines(0, 0); check(exp_btn(0), "R8 pad1 btn after clr low");
    lines(0, 1); check(4'b0000, "R7 clr forces zero");
    lines(1, 1); check(4'b0000, "R7 sel edge with clr high");
    lines(1, 0); check(exp_dir(0), "R3 no advance while clr high");
    lines(0, 0);
    lines(1, 0); check(exp_dir(1), "R3 advance to pad2");
  endtask

  initial begin
    pad[0] = 8'b1000_0001; pad[1] = 8'b0100_0010; pad[2] = 8'b0010_0100;
    pad[3] = 8'b1111_1111; pad[4] = 8'b0001_1000;
    present = 5'b10111;
    sel = 1'b0; clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_powerup();
    t_clr_sel_low_no_start();
    t_full_scan("A");
    pad[0] = 8'b0101_1010; pad[1] = 8'b1010_0101; pad[2] = 8'b1100_0011;
    pad[4] = 8'b0011_1100;
    t_full_scan("B");
    t_clr_blocks();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule